// File: doc/BRIEF.md
# Scan-Chain Interconnect Stuck-Fault Diagnosis Sequencer

This block is a self-running master for a serial boundary-scan chain. It drives the chain's test clock, mode-select and serial data lines on its own, and it reads back the serial data that returns from the end of the chain. A parameter map describes the chain. For each device it gives the instruction-register length, the boundary-register length and a mask that marks which boundary cells are output-enable controls. When `start` is pulsed, the sequencer does the following in order:

- It walks the chain's test controllers to their reset state.
- It loads the external-test opcode into every device in one instruction scan.
- It runs three data scans. The data cells carry ones in the first scan and zeros in the second and third. Every control cell is driven to 0 in all three, so that no net floats.

Each scan returns the values captured from the nets, which were set by the previous scan's update. The sequencer ignores the first returned stream. It compares the second stream with ones and the third with zeros, and it skips control positions. It reports the first data position that differs, together with the stuck value seen there.

Chain positions are counted from the serial-output end. Position 0 is the cell nearest the chain's output, and it is both the first bit shifted out and the first bit shifted in. Devices are listed from the serial-input end, so device `NUM_DEV-1` holds positions 0 to `BSR_LEN[NUM_DEV-1]-1`. None of the pins is a stream with back-pressure. `start` is a plain request. It is ignored while `busy` is high, and results stay on their pins until the next accepted `start`.

Top module: `scandiag_seq`

## Requirements
- R1: After `start`, the mode-select line is 1 for five test-clock rising edges and then 0 for one, so every device passes through its reset state before the instruction scan.
- R2: One instruction scan shifts exactly the sum of all instruction lengths, with every bit 0 (the external-test opcode is all zeros in every device). The last bit goes out with mode-select 1, and the scan ends in the update state.
- R3: Exactly three data scans follow, each shifting exactly the chain length. Data cells carry 1 in scan 0 and 0 in scans 1 and 2. Control cells carry 0 in every scan. Bit k shifted in lands at position k.
- R4: The stream returned during scan 0 never raises `fault_found`.
- R5: Returned bits at control-cell positions are never compared.
- R6: A data cell returned as 0 where the previous scan drove 1 sets `fault_found`, and `fault_stuck_one` is 0.
- R7: A data cell returned as 1 where the previous scan drove 0 sets `fault_found`, and `fault_stuck_one` is 1.
- R8: With several mismatches, the earliest scan wins, and within a scan the lowest position wins. `fault_net` holds that position and does not change afterwards in the run.
- R9: `done` pulses for one cycle after the last update and return to idle. Results hold until the next accepted `start`. A `start` while `busy` is high adds no scans.
- R10: The test-clock period is 2*`HALF` system cycles within a run. Mode-select and serial output change only while the test clock is low, and the test clock is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one diagnosis run (ignored while busy) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fault_found | output | 1 | A data-cell mismatch was seen in this run |
| fault_net | output | NET_W | Chain position of the first mismatch |
| fault_stuck_one | output | 1 | 1: stuck-at-1, 0: stuck-at-0 |
| scan_clk | output | 1 | Test clock to the chain |
| scan_sel | output | 1 | Mode-select to the chain |
| scan_do | output | 1 | Serial data into the first device |
| scan_di | input | 1 | Serial data from the last device |

## Verification
The bench model captures the previous update onto every net, which is a fault-free loop. It starts with all ones, and its control cells return the complement of what they were driven. A clean run therefore shows that both the first capture and the control positions are ignored, because either one would otherwise raise a false fault. A single stuck-at-0 or stuck-at-1 on a data net tells the two fault types apart, including at positions 0 and the last data cell. Pairs of faults tell "earliest scan" apart from "lowest position". A `start` pulsed mid-run shows that no extra scan is issued.

// File: rtl/scandiag_pkg.sv
package scandiag_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_RST,
    SQ_IR_HDR,
    SQ_IR_SH,
    SQ_IR_END,
    SQ_DR_HDR,
    SQ_DR_SH,
    SQ_DR_END,
    SQ_FIN
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } clk_ph_t;

  localparam int RST_ONES = 5;

endpackage

// File: rtl/scandiag_clkgen.sv
module scandiag_clkgen
  import scandiag_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic sel_in,
  input  logic dat_in,
  output logic scan_clk,
  output logic scan_sel,
  output logic scan_do,
  input  logic scan_di,
  output logic smp_valid,
  output logic smp_bit
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] HEND = HW'(HALF - 1);

  clk_ph_t        ph;
  logic [HW-1:0]  cnt;

  assign bit_ready = (ph == PH_IDLE) || (ph == PH_HIGH && cnt == HEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      scan_clk  <= 1'b0;
      scan_sel  <= 1'b0;
      scan_do   <= 1'b0;
      smp_valid <= 1'b0;
      smp_bit   <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      case (ph)
        PH_LOW: begin
          if (cnt == HEND) begin
            scan_clk  <= 1'b1;
            smp_valid <= 1'b1;
            smp_bit   <= scan_di;
            ph        <= PH_HIGH;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == HEND) begin
            scan_clk <= 1'b0;
            ph       <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
      if (bit_valid && bit_ready) begin
        scan_sel <= sel_in;
        scan_do  <= dat_in;
        ph       <= PH_LOW;
        cnt      <= '0;
      end
    end
  end

endmodule

// File: rtl/scandiag_cmp.sv
module scandiag_cmp #(
  parameter int POS_W = 5,
  parameter int NET_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chk_en,
  input  logic             ctrl_cell,
  input  logic             exp_bit,
  input  logic             got_bit,
  input  logic [POS_W-1:0] pos,
  output logic             found,
  output logic [NET_W-1:0] net,
  output logic             stuck_one
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found     <= 1'b0;
      net       <= '0;
      stuck_one <= 1'b0;
    end else if (clr) begin
      found     <= 1'b0;
      net       <= '0;
      stuck_one <= 1'b0;
    end else if (chk_en && !ctrl_cell && !found && (got_bit != exp_bit)) begin
      found     <= 1'b1;
      net       <= NET_W'(pos);
      stuck_one <= got_bit;
    end
  end

endmodule

// File: rtl/scandiag_seq.sv
module scandiag_seq
  import scandiag_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int MAX_BSR = 16,
  parameter int HALF    = 2,
  parameter int NET_W   = 5,
  parameter int IR_LEN  [NUM_DEV] = '{8, 3, 8},
  parameter int BSR_LEN [NUM_DEV] = '{10, 3, 10},
  parameter logic [MAX_BSR-1:0] CTRL_MASK [NUM_DEV] = '{16'h0201, 16'h0004, 16'h0030}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             fault_found,
  output logic [NET_W-1:0] fault_net,
  output logic             fault_stuck_one,
  output logic             scan_clk,
  output logic             scan_sel,
  output logic             scan_do,
  input  logic             scan_di
);

  function automatic int sum_ir();
    int s = 0;
    for (int i = 0; i < NUM_DEV; i++) s += IR_LEN[i];
    return s;
  endfunction

  function automatic int sum_bsr();
    int s = 0;
    for (int i = 0; i < NUM_DEV; i++) s += BSR_LEN[i];
    return s;
  endfunction

  localparam int IR_TOTAL  = sum_ir();
  localparam int CHAIN_LEN = sum_bsr();

  // Position 0 is the cell nearest the serial output: walk devices from that end.
  function automatic logic [CHAIN_LEN-1:0] ctrl_map();
    logic [CHAIN_LEN-1:0] m = '0;
    int pos = 0;
    for (int d = NUM_DEV - 1; d >= 0; d--) begin
      for (int k = 0; k < BSR_LEN[d]; k++) begin
        m[pos] = CTRL_MASK[d][k];
        pos++;
      end
    end
    return m;
  endfunction

  localparam logic [CHAIN_LEN-1:0] CHAIN_CTRL = ctrl_map();
  localparam int LONGEST = (IR_TOTAL > CHAIN_LEN) ? IR_TOTAL : CHAIN_LEN;
  localparam int CNT_W   = $clog2(LONGEST + 8);
  localparam int POS_W   = $clog2(CHAIN_LEN);
  localparam logic [CNT_W-1:0] IR_LAST = CNT_W'(IR_TOTAL - 1);
  localparam logic [CNT_W-1:0] DR_LAST = CNT_W'(CHAIN_LEN - 1);

  seq_st_t          st, nxt_st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       scan;
  logic             bit_valid, bit_ready, accept, last_bit;
  logic             sel_n, dat_n;
  logic [POS_W-1:0] pos;
  logic             smp_valid, smp_bit;
  logic             smp_chk, smp_exp;
  logic [POS_W-1:0] smp_pos;
  logic             cmp_clr;

  assign pos     = cnt[POS_W-1:0];
  assign accept  = bit_valid && bit_ready;
  assign busy    = (st != SQ_IDLE);
  assign cmp_clr = (st == SQ_IDLE) && start;

  always_comb begin
    bit_valid = 1'b1;
    sel_n     = 1'b0;
    dat_n     = 1'b0;
    last_bit  = 1'b0;
    nxt_st    = st;
    case (st)
      SQ_RST: begin
        sel_n    = (cnt < CNT_W'(RST_ONES));
        last_bit = (cnt == CNT_W'(RST_ONES));
        nxt_st   = SQ_IR_HDR;
      end
      SQ_IR_HDR: begin
        sel_n    = (cnt < CNT_W'(2));
        last_bit = (cnt == CNT_W'(3));
        nxt_st   = SQ_IR_SH;
      end
      SQ_IR_SH: begin
        sel_n    = (cnt == IR_LAST);
        last_bit = sel_n;
        nxt_st   = SQ_IR_END;
      end
      SQ_IR_END: begin
        sel_n    = (cnt == '0);
        last_bit = (cnt == CNT_W'(1));
        nxt_st   = SQ_DR_HDR;
      end
      SQ_DR_HDR: begin
        sel_n    = (cnt == '0);
        last_bit = (cnt == CNT_W'(2));
        nxt_st   = SQ_DR_SH;
      end
      SQ_DR_SH: begin
        sel_n    = (cnt == DR_LAST);
        last_bit = sel_n;
        dat_n    = !CHAIN_CTRL[pos] && (scan == 2'd0);
        nxt_st   = SQ_DR_END;
      end
      SQ_DR_END: begin
        sel_n    = (cnt == '0);
        last_bit = (cnt == CNT_W'(1));
        nxt_st   = (scan == 2'd2) ? SQ_FIN : SQ_DR_HDR;
      end
      default: bit_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cnt     <= '0;
      scan    <= '0;
      done    <= 1'b0;
      smp_chk <= 1'b0;
      smp_exp <= 1'b0;
      smp_pos <= '0;
    end else begin
      done <= 1'b0;
      if (st == SQ_IDLE) begin
        if (start) begin
          st   <= SQ_RST;
          cnt  <= '0;
          scan <= '0;
        end
      end else if (st == SQ_FIN) begin
        if (bit_ready) begin
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
      end else if (accept) begin
        smp_chk <= (st == SQ_DR_SH) && (scan != 2'd0);
        smp_exp <= (scan == 2'd1);
        smp_pos <= pos;
        if (last_bit) begin
          cnt <= '0;
          st  <= nxt_st;
          if (st == SQ_DR_END && scan != 2'd2) scan <= scan + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  scandiag_clkgen #(.HALF(HALF)) clkgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .sel_in    (sel_n),
    .dat_in    (dat_n),
    .scan_clk  (scan_clk),
    .scan_sel  (scan_sel),
    .scan_do   (scan_do),
    .scan_di   (scan_di),
    .smp_valid (smp_valid),
    .smp_bit   (smp_bit)
  );

  scandiag_cmp #(.POS_W(POS_W), .NET_W(NET_W)) cmp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmp_clr),
    .chk_en    (smp_valid && smp_chk),
    .ctrl_cell (CHAIN_CTRL[smp_pos]),
    .exp_bit   (smp_exp),
    .got_bit   (smp_bit),
    .pos       (smp_pos),
    .found     (fault_found),
    .net       (fault_net),
    .stuck_one (fault_stuck_one)
  );

endmodule

// File: rtl/scandiag_seq_chk.sv
module scandiag_seq_chk #(
  parameter int NET_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fault_found,
  input logic [NET_W-1:0] fault_net,
  input logic             scan_clk,
  input logic             scan_sel,
  input logic             scan_do
);

  AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scan_clk |-> ($stable(scan_sel) && $stable(scan_do))); // R10

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scan_clk); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(fault_found) && $stable(fault_net))); // R9

  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_found && $past(fault_found)) |-> $stable(fault_net)); // R8

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done)); // R9

endmodule

bind scandiag_seq scandiag_seq_chk #(.NET_W(NET_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .fault_found (fault_found),
  .fault_net   (fault_net),
  .scan_clk    (scan_clk),
  .scan_sel    (scan_sel),
  .scan_do     (scan_do)
);

// File: tb/scandiag_seq_tb_top.sv
module scandiag_seq_tb_top;

  localparam int L   = 23;
  localparam int IRT = 19;
  localparam int NW  = 5;
  localparam int HALF = 2;
  localparam int DEVN = 3;
  localparam int MB  = 16;
  localparam int TB_IR  [DEVN] = '{8, 3, 8};
  localparam int TB_BSR [DEVN] = '{10, 3, 10};
  localparam logic [MB-1:0] TB_MASK [DEVN] = '{16'h0201, 16'h0004, 16'h0030};

  typedef enum logic [3:0] {
    T_RST, T_IDLE, T_SELD, T_CAPD, T_SHD, T_EX1D, T_PAD, T_EX2D, T_UPD,
    T_SELI, T_CAPI, T_SHI, T_EX1I, T_PAI, T_EX2I, T_UPI
  } tst_t;

  typedef struct packed {
    logic          found;
    logic [NW-1:0] net;
    logic          stuck;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, fault_found, fault_stuck_one;
  logic [NW-1:0] fault_net;
  logic scan_clk, scan_sel, scan_do;
  logic scan_di = 1'b0;

  always #10 clk = ~clk;

  scandiag_seq #(
    .NUM_DEV(DEVN), .MAX_BSR(MB), .HALF(HALF), .NET_W(NW),
    .IR_LEN(TB_IR), .BSR_LEN(TB_BSR), .CTRL_MASK(TB_MASK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fault_found(fault_found), .fault_net(fault_net),
    .fault_stuck_one(fault_stuck_one), .scan_clk(scan_clk),
    .scan_sel(scan_sel), .scan_do(scan_do), .scan_di(scan_di)
  );

  // bench-side chain map, position 0 nearest the serial output
  logic [L-1:0] tb_ctrl;
  initial begin
    int p = 0;
    tb_ctrl = '0;
    for (int d = DEVN - 1; d >= 0; d--)
      for (int k = 0; k < TB_BSR[d]; k++) begin
        tb_ctrl[p] = TB_MASK[d][k];
        p++;
      end
  end

  // fault injection on nets (data cells)
  logic f_en [2];
  int   f_pos [2];
  logic f_val [2];

  function automatic logic net_val(int p, logic v);
    logic r = v;
    for (int s = 0; s < 2; s++)
      if (f_en[s] && f_pos[s] == p) r = f_val[s];
    return r;
  endfunction

  logic [L-1:0] q_upd [$];
  res_t         q_res [$];

  int n_chk = 0, n_bad = 0;
  int m_chk = 0, m_bad = 0;
  int r_chk = 0, r_bad = 0;
  int runs_done = 0;

  // chain model
  tst_t         ts = T_RST;
  logic [L-1:0] dr_sr = '0;
  logic [L-1:0] upd = '1;
  logic [IRT-1:0] ir_sr = '0;
  int dr_cnt = 0, ir_cnt = 0;
  logic rst_seen = 1'b0;

  function automatic tst_t nxt(tst_t s, logic m);
    case (s)
      T_RST:  return m ? T_RST  : T_IDLE;
      T_IDLE: return m ? T_SELD : T_IDLE;
      T_SELD: return m ? T_SELI : T_CAPD;
      T_CAPD: return m ? T_EX1D : T_SHD;
      T_SHD:  return m ? T_EX1D : T_SHD;
      T_EX1D: return m ? T_UPD  : T_PAD;
      T_PAD:  return m ? T_EX2D : T_PAD;
      T_EX2D: return m ? T_UPD  : T_SHD;
      T_UPD:  return m ? T_SELD : T_IDLE;
      T_SELI: return m ? T_RST  : T_CAPI;
      T_CAPI: return m ? T_EX1I : T_SHI;
      T_SHI:  return m ? T_EX1I : T_SHI;
      T_EX1I: return m ? T_UPI  : T_PAI;
      T_PAI:  return m ? T_EX2I : T_PAI;
      T_EX2I: return m ? T_UPI  : T_SHI;
      default: return m ? T_SELD : T_IDLE;
    endcase
  endfunction

  always @(posedge scan_clk) begin
    case (ts)
      T_RST: rst_seen <= 1'b1;
      T_CAPD: begin
        for (int p = 0; p < L; p++)
          dr_sr[p] <= tb_ctrl[p] ? ~upd[p] : net_val(p, upd[p]);
        dr_cnt <= 0;
      end
      T_SHD: begin
        dr_sr  <= {scan_do, dr_sr[L-1:1]};
        dr_cnt <= dr_cnt + 1;
      end
      T_UPD: begin
        upd <= dr_sr;
        m_chk++;
        if (q_upd.size() == 0) begin
          m_bad++;
          $display("FAIL R9 extra data scan actual=%0h expected=none", dr_sr);
        end else begin
          logic [L-1:0] e;
          e = q_upd.pop_front();
          if (dr_sr !== e) begin
            m_bad++;
            $display("FAIL R3 driven pattern actual=%0h expected=%0h", dr_sr, e);
          end
        end
        m_chk++;
        if (dr_cnt != L) begin
          m_bad++;
          $display("FAIL R3 data shift length actual=%0d expected=%0d", dr_cnt, L);
        end
      end
      T_CAPI: begin
        ir_sr  <= IRT'(1);
        ir_cnt <= 0;
      end
      T_SHI: begin
        ir_sr  <= {scan_do, ir_sr[IRT-1:1]};
        ir_cnt <= ir_cnt + 1;
      end
      T_UPI: begin
        m_chk += 3;
        if (ir_sr !== '0) begin
          m_bad++;
          $display("FAIL R2 opcode actual=%0h expected=0", ir_sr);
        end
        if (ir_cnt != IRT) begin
          m_bad++;
          $display("FAIL R2 instruction length actual=%0d expected=%0d", ir_cnt, IRT);
        end
        if (!rst_seen) begin
          m_bad++;
          $display("FAIL R1 reset state not visited actual=0 expected=1");
        end
        rst_seen <= 1'b0;
      end
      default: ;
    endcase
    ts <= nxt(ts, scan_sel);
  end

  always @(negedge scan_clk)
    scan_di <= (ts == T_SHD) ? dr_sr[0] : (ts == T_SHI) ? ir_sr[0] : 1'b0;

  // result monitor
  always @(negedge clk) begin
    if (done) begin
      r_chk++;
      if (q_res.size() == 0) begin
        r_bad++;
        $display("FAIL R9 unexpected done actual=1 expected=0");
      end else begin
        res_t e, a;
        e = q_res.pop_front();
        a = '{found: fault_found, net: fault_net, stuck: fault_stuck_one};
        if (!e.found) a.net = '0;
        if (!e.found) a.stuck = 1'b0;
        if (a !== e) begin
          r_bad++;
          $display("FAIL R6/R7/R8 result found/net/stuck actual=%0h expected=%0h", a, e);
        end
      end
      runs_done++;
    end
  end

  // test-clock period monitor (R10)
  logic tck_prev = 1'b0;
  int   gcnt = 0, gap_bad = 0, gap_n = 0;
  logic gap_ok = 1'b0;
  always @(negedge clk) begin
    tck_prev <= scan_clk;
    if (!busy) begin
      gap_ok <= 1'b0;
    end else if (scan_clk && !tck_prev) begin
      if (gap_ok) begin
        gap_n++;
        if (gcnt != 2 * HALF) gap_bad++;
      end
      gap_ok <= 1'b1;
      gcnt   <= 1;
    end else begin
      gcnt <= gcnt + 1;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic e0, input int p0, input logic v0,
                          input logic e1, input int p1, input logic v1,
                          input bit poke, input string tag);
    res_t r;
    int   target;
    f_en[0] = e0; f_pos[0] = p0; f_val[0] = v0;
    f_en[1] = e1; f_pos[1] = p1; f_val[1] = v1;
    // driven patterns (R3): data cells 1,0,0; control cells 0
    for (int k = 0; k < 3; k++) begin
      logic [L-1:0] pat;
      for (int p = 0; p < L; p++) pat[p] = !tb_ctrl[p] && (k == 0);
      q_upd.push_back(pat);
    end
    // expected result: scans 1 and 2 checked against previous drive (R4..R8)
    r = '0;
    for (int k = 1; k < 3; k++)
      for (int p = 0; p < L; p++) begin
        logic ev, gv;
        ev = (k == 1);
        gv = net_val(p, ev);
        if (!r.found && !tb_ctrl[p] && gv != ev) begin
          r.found = 1'b1;
          r.net   = NW'(p);
          r.stuck = gv;
        end
      end
    q_res.push_back(r);
    target = runs_done + 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait (runs_done == target);
    repeat (20) @(negedge clk);
    check(q_upd.size() == 0, {"R9 scans left ", tag}, q_upd.size(), 0);
    check(!busy, {"R9 idle after run ", tag}, busy, 0);
    check(fault_found == r.found, {"R9 held found ", tag}, fault_found, r.found);
    if (r.found)
      check(fault_net == r.net, {"R9 held net ", tag}, fault_net, r.net);
    check(gap_bad == 0 && gap_n > 0, {"R10 clock period ", tag}, gap_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + m_chk + r_chk + 1,
             n_bad + m_bad + r_bad + 1);
    $finish;
  end

  initial begin
    f_en[0] = 1'b0; f_en[1] = 1'b0;
    f_pos[0] = 0; f_pos[1] = 0;
    f_val[0] = 1'b0; f_val[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R9 reset busy", busy, 0);
    check(!done, "R9 reset done", done, 0);
    check(!scan_clk, "R10 reset clock low", scan_clk, 0);
    check(!fault_found, "R4 reset found", fault_found, 0);

    run_case(0, 0, 0, 0, 0, 0, 0, "clean R4 R5");
    run_case(1, 2, 0, 0, 0, 0, 0, "sa0 R6");
    run_case(1, 20, 1, 0, 0, 0, 0, "sa1 R7");
    run_case(1, 0, 0, 0, 0, 0, 0, "sa0 pos0 R6");
    run_case(1, 21, 1, 0, 0, 0, 0, "sa1 last R7");
    run_case(1, 3, 1, 1, 18, 0, 0, "scan order R8");
    run_case(1, 15, 0, 1, 7, 0, 0, "position order R8");
    run_case(1, 14, 1, 1, 9, 1, 1, "busy start R9");
    run_case(0, 0, 0, 0, 0, 0, 0, "clean again R4");

    $display("  test done: total=%0d bad=%0d", n_chk + m_chk + r_chk,
             n_bad + m_bad + r_bad);
    $finish;
  end

endmodule